// File: doc/BRIEF.md
# Byte-Count Tagged FIFO Front End for a Serial Flash Controller

This block sits between a CPU register port and the byte shifter of a serial flash controller. On the transmit side the CPU stores 32-bit words through one of four write addresses. One address stores a whole word. The other three store a short word that holds one, two or three valid bytes. Each queued entry keeps a two-bit byte-count tag beside its data. The shifter reads the queue one byte at a time, starting with the least-significant lane. It sends only the bytes that the tag allows, so the filler in the unused upper lanes never reaches the wire.

On the receive side the shifter hands in one byte at a time, together with a flag that marks the final byte of the current transmit word. The block gathers the bytes into a word. It queues the word after four bytes, or earlier when the flag shows that a short word has ended. A short received word is stored with its bytes moved up to the most-significant lanes and its lower lanes cleared. The CPU reads finished words from a single receive address.

Overflow and underflow are not stored anywhere. A transmit write that finds the queue full is dropped and gives a one-cycle pulse. A receive read that finds the queue empty returns zero and gives a one-cycle pulse.

Top module: `qfe_front`

## Requirements
- R1: A write (`bus_wr`) to address 0x1C queues `bus_wdata` with tag 00, which means 4 bytes. Writes to 0x80, 0x84 and 0x88 queue it with tags 01, 10 and 11, which mean 1, 2 and 3 bytes. A write to any other address, including 0x20, queues nothing.
- R2: The bytes of each entry appear on `sh_byte` starting with bits 7:0 and moving upward one lane at a time. Only as many bytes as the tag gives are presented, so lanes above the tagged count are never sent.
- R3: `sh_end` is high while the final tagged byte of an entry is presented. An entry leaves the queue only on the cycle in which `sh_req` takes that final byte. Entries are sent in the order they were written.
- R4: A transmit write that finds the queue holding `FIFO_DEPTH` entries is discarded. `tx_overflow` is high for exactly the following cycle.
- R5: Received bytes are gathered into a word with the first byte in bits 7:0. The word is queued when its fourth byte arrives, even if `rx_last` stays low.
- R6: When `rx_last` comes with the n-th byte (n = 1, 2 or 3), the word is queued at once. The first byte sits in lane 4-n, the last byte sits in bits 31:24, and all lanes below are zero.
- R7: A read (`bus_rd`) at address 0x20 from a non-empty receive queue places the oldest word on `bus_rdata` in the next cycle and removes that word. `bus_rdata` keeps its value on all other cycles.
- R8: A read at 0x20 from an empty receive queue sets `bus_rdata` to zero and pulses `rx_underflow` for one cycle.
- R9: After reset both queues are empty, the byte gather is cleared, `sh_valid` is low, `bus_rdata` is zero and both pulse outputs are low.
- R10: A received word that completes while the receive queue is full is discarded. The words already queued are unchanged.
- R11: `sh_valid` is high exactly when the transmit queue holds an entry. A `sh_req` while `sh_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a receive read |
| tx_overflow | output | 1 | One-cycle pulse: transmit write dropped |
| rx_underflow | output | 1 | One-cycle pulse: receive read found the queue empty |
| sh_req | input | 1 | Shifter takes the presented byte |
| sh_valid | output | 1 | A transmit byte is presented |
| sh_byte | output | 8 | Presented transmit byte |
| sh_end | output | 1 | Presented byte is the final byte of its entry |
| rx_valid | input | 1 | A received byte is offered |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | Received byte closes the current transmit word |

## Verification
The bench builds the block with `FIFO_DEPTH` set to 4 instead of 63. With a depth of 4, a full transmit queue and a full receive queue each take only a few writes or received words to reach. This brings the dropped-write pulse and the discarded-received-word path into a short run. A queue model in the bench steps alongside the design and compares every output on every clock. This includes the byte order across 1-, 2-, 3- and 4-byte entries, with pauses in `sh_req`. It also includes upper-lane alignment for short received words of every length.

// File: rtl/qfe_pkg.sv
package qfe_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int TAG_W     = 2;
    localparam int DEPTH_DEF = 63;

    // Write and read addresses. Software relies on these exact offsets.
    localparam logic [ADDR_W-1:0] A_TX4 = 8'h1C;
    localparam logic [ADDR_W-1:0] A_TX1 = 8'h80;
    localparam logic [ADDR_W-1:0] A_TX2 = 8'h84;
    localparam logic [ADDR_W-1:0] A_TX3 = 8'h88;
    localparam logic [ADDR_W-1:0] A_RXD = 8'h20;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;   // 00 = four bytes, otherwise the byte count
        logic [DATA_W-1:0] data;
    } tx_entry_t;

    typedef struct packed {
        logic             hit;
        logic [TAG_W-1:0] tag;
    } tx_dec_t;

    function automatic tx_dec_t decode_tx(input logic [ADDR_W-1:0] a);
        tx_dec_t d;
        d.hit = 1'b1;
        case (a)
            A_TX4:   d.tag = 2'd0;
            A_TX1:   d.tag = 2'd1;
            A_TX2:   d.tag = 2'd2;
            A_TX3:   d.tag = 2'd3;
            default: begin d.hit = 1'b0; d.tag = 2'd0; end
        endcase
        return d;
    endfunction

    // Index of the final byte lane that an entry with this tag sends.
    function automatic logic [1:0] last_lane(input logic [TAG_W-1:0] t);
        return (t == 2'd0) ? 2'd3 : t - 2'd1;
    endfunction
endpackage

// File: rtl/qfe_fifo.sv
module qfe_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 63
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CFULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= pdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/qfe_tx_unpack.sv
module qfe_tx_unpack
    import qfe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tx_entry_t head,
    input  logic      empty,
    input  logic      sh_req,
    output logic      sh_valid,
    output logic [7:0] sh_byte,
    output logic      sh_end,
    output logic      pop
);
    logic [1:0] lane;

    assign sh_valid = !empty;
    assign sh_byte  = head.data[{lane, 3'b000} +: 8];
    assign sh_end   = sh_valid && (lane == last_lane(head.tag));
    assign pop      = sh_req && sh_end;

    always_ff @(posedge clk) begin
        if (rst)                       lane <= '0;
        else if (pop)                  lane <= '0;
        else if (sh_req && sh_valid)   lane <= lane + 1'b1;
    end
endmodule

// File: rtl/qfe_rx_pack.sv
module qfe_rx_pack
    import qfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_last,
    output logic              push,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] acc;
    logic [1:0]        cnt;

    // New bytes enter at the top lane and earlier ones move down, so a
    // short word finishes with its bytes in the upper lanes.
    assign word = {rx_byte, acc[DATA_W-1:8]};
    assign push = rx_valid && (rx_last || cnt == 2'd3);

    always_ff @(posedge clk) begin
        if (rst || push) begin
            acc <= '0;
            cnt <= '0;
        end else if (rx_valid) begin
            acc <= word;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/qfe_front.sv
module qfe_front
    import qfe_pkg::*;
#(
    parameter int FIFO_DEPTH = DEPTH_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                tx_overflow,
    output logic                rx_underflow,
    input  logic                sh_req,
    output logic                sh_valid,
    output logic [7:0]          sh_byte,
    output logic                sh_end,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic                rx_last
);
    localparam int TXW = $bits(tx_entry_t);

    tx_dec_t           dec;
    tx_entry_t         tx_in, tx_head;
    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_pop, rx_empty, rx_full, rd_hit;
    logic [DATA_W-1:0] rx_word, rx_head;

    assign dec       = decode_tx(bus_addr);
    assign tx_push   = bus_wr && dec.hit;
    assign tx_in.tag = dec.tag;
    assign tx_in.data = bus_wdata;

    qfe_fifo #(.W(TXW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .pdata(tx_in), .pop(tx_pop),
        .head(tx_head), .empty(tx_empty), .full(tx_full)
    );

    qfe_tx_unpack u_unpack (
        .clk(clk), .rst(rst), .head(tx_head), .empty(tx_empty), .sh_req(sh_req),
        .sh_valid(sh_valid), .sh_byte(sh_byte), .sh_end(sh_end), .pop(tx_pop)
    );

    qfe_rx_pack u_pack (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_last(rx_last), .push(rx_push), .word(rx_word)
    );

    assign rd_hit = bus_rd && (bus_addr == A_RXD);
    assign rx_pop = rd_hit && !rx_empty;

    qfe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .pdata(rx_word), .pop(rx_pop),
        .head(rx_head), .empty(rx_empty), .full(rx_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata    <= '0;
            tx_overflow  <= 1'b0;
            rx_underflow <= 1'b0;
        end else begin
            tx_overflow  <= tx_push && tx_full;
            rx_underflow <= rd_hit && rx_empty;
            if (rd_hit) bus_rdata <= rx_empty ? '0 : rx_head;
        end
    end
endmodule

// File: rtl/qfe_front_chk.sv
module qfe_front_chk
    import qfe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_overflow,
    input logic              rx_underflow,
    input logic              sh_req,
    input logic              sh_valid,
    input logic              sh_end,
    input logic              tx_full,
    input logic              rx_empty,
    input tx_entry_t         tx_head
);
    logic tx_wr, rx_rd;
    assign tx_wr = bus_wr && decode_tx(bus_addr).hit;
    assign rx_rd = bus_rd && (bus_addr == A_RXD);

    assert_drop_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_full) |=> tx_overflow);

    assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |-> $past(bus_wr));

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && rx_empty) |=> (rx_underflow && bus_rdata == '0));

    assert_good_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !rx_empty) |=> !rx_underflow);

    assert_hold_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (sh_req && sh_valid && !sh_end) |=> (sh_valid && $stable(tx_head)));
endmodule

bind qfe_front qfe_front_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .tx_overflow(tx_overflow), .rx_underflow(rx_underflow),
    .sh_req(sh_req), .sh_valid(sh_valid), .sh_end(sh_end), .tx_full(tx_full),
    .rx_empty(rx_empty), .tx_head(tx_head)
);

// File: tb/tb_qfe_front.sv
`timescale 1ns/1ps
module tb_qfe_front;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_overflow, rx_underflow;
    logic        sh_req = 0, sh_valid, sh_end;
    logic [7:0]  sh_byte;
    logic        rx_valid = 0, rx_last = 0;
    logic [7:0]  rx_byte = '0;

    int total = 0, bad = 0;

    always #2 clk = ~clk;

    qfe_front #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_overflow(tx_overflow),
        .rx_underflow(rx_underflow), .sh_req(sh_req), .sh_valid(sh_valid),
        .sh_byte(sh_byte), .sh_end(sh_end), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_last(rx_last)
    );

    // Behavioural reference: queues and counters only.
    logic [33:0] m_tx[$];
    logic [31:0] m_rx[$];
    int          m_lane = 0, m_cnt = 0;
    logic [31:0] m_acc = '0, m_rdata = '0;
    bit          m_ovf = 0, m_udf = 0;

    function automatic int nbytes(input logic [1:0] t);
        return (t == 2'd0) ? 4 : int'(t);
    endfunction

    function automatic int tag_of(input logic [7:0] a);
        case (a)
            8'h1C: return 0;
            8'h80: return 1;
            8'h84: return 2;
            8'h88: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        bit ev = (m_tx.size() > 0);
        check(sh_valid == ev, "R11 sh_valid", 32'(sh_valid), 32'(ev));
        if (ev) begin
            logic [33:0] h = m_tx[0];
            logic [7:0]  eb = h[8*m_lane +: 8];
            bit          ee = (m_lane == nbytes(h[33:32]) - 1);
            check(sh_byte == eb, "R2 sh_byte", 32'(sh_byte), 32'(eb));
            check(sh_end == ee, "R3 sh_end", 32'(sh_end), 32'(ee));
        end
        check(bus_rdata == m_rdata, "R7 bus_rdata", bus_rdata, m_rdata);
        check(tx_overflow == m_ovf, "R4 tx_overflow", 32'(tx_overflow), 32'(m_ovf));
        check(rx_underflow == m_udf, "R8 rx_underflow", 32'(rx_underflow), 32'(m_udf));
    endtask

    // One clock: model next state from the current inputs, edge, commit, compare.
    task automatic cyc();
        int  t = bus_wr ? tag_of(bus_addr) : -1;
        bit  tpop = 0, rpop = 0;
        int  txn = m_tx.size(), rxn = m_rx.size();
        int  nlane = m_lane;
        logic [31:0] nrd = m_rdata, nacc = m_acc;
        int  ncnt = m_cnt;
        bit  nudf = 0, rpush = 0;
        logic [31:0] rword = '0;
        if (sh_req && txn > 0) begin
            if (m_lane == nbytes(m_tx[0][33:32]) - 1) begin tpop = 1; nlane = 0; end
            else nlane = m_lane + 1;
        end
        if (bus_rd && bus_addr == 8'h20) begin
            if (rxn > 0) begin nrd = m_rx[0]; rpop = 1; end
            else begin nrd = '0; nudf = 1; end
        end
        if (rx_valid) begin
            rword = {rx_byte, m_acc[31:8]};
            if (rx_last || m_cnt == 3) begin
                rpush = (rxn < DEPTH); nacc = '0; ncnt = 0;
            end else begin nacc = rword; ncnt = m_cnt + 1; end
        end
        @(posedge clk);
        #1;
        if (tpop) void'(m_tx.pop_front());
        if (t >= 0 && txn < DEPTH) m_tx.push_back({2'(t), bus_wdata});
        m_ovf = (t >= 0 && txn >= DEPTH);
        if (rpop) void'(m_rx.pop_front());
        if (rpush) m_rx.push_back(rword);
        m_lane = nlane; m_rdata = nrd; m_udf = nudf; m_acc = nacc; m_cnt = ncnt;
        compare_all();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_rd = 1; bus_addr = a;
        cyc();
        bus_rd = 0;
    endtask

    task automatic rxb(input logic [7:0] b, input bit last);
        rx_valid = 1; rx_byte = b; rx_last = last;
        cyc();
        rx_valid = 0; rx_last = 0;
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] got_b[$];
        bit         got_e[$];
        logic [7:0] exp_b[10] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55,
                                   8'h66, 8'h77, 8'h88, 8'h99, 8'hAA};
        bit         exp_e[10] = '{0, 0, 0, 1, 1, 0, 1, 0, 0, 1};
        logic [31:0] exp_w[4] = '{32'h44332211, 32'hA2A10000,
                                   32'hB1000000, 32'hC3C2C100};

        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R9: reset state
        check(sh_valid == 0, "R9 sh_valid", 32'(sh_valid), 0);
        check(bus_rdata == 0, "R9 bus_rdata", bus_rdata, 0);
        check(tx_overflow == 0 && rx_underflow == 0, "R9 pulses",
              {tx_overflow, rx_underflow}, 0);
        sh_req = 1;
        cyc();                        // R11: request with nothing queued
        check(sh_valid == 0, "R11 idle request", 32'(sh_valid), 0);
        sh_req = 0;

        // R1: every size of write, plus writes that must not queue
        wr(8'h1C, 32'h44332211);
        wr(8'h80, 32'hFFFFFF55);
        wr(8'h40, 32'h12345678);
        wr(8'h20, 32'h9ABCDEF0);
        wr(8'h84, 32'hFFFF7766);
        wr(8'h88, 32'hFFAA9988);
        wr(8'h1C, 32'hDEADBEEF);     // queue full
        check(tx_overflow == 1, "R4 dropped write", 32'(tx_overflow), 1);
        cyc();
        check(tx_overflow == 0, "R4 single pulse", 32'(tx_overflow), 0);

        // R2 R3: drain with gaps in the request
        for (int i = 0; i < 40 && got_b.size() < 12; i++) begin
            sh_req = (i % 3 != 2);
            if (sh_req && sh_valid) begin got_b.push_back(sh_byte); got_e.push_back(sh_end); end
            cyc();
        end
        sh_req = 0;
        check(got_b.size() == 10, "R1 byte count", got_b.size(), 10);
        for (int i = 0; i < 10 && i < got_b.size(); i++) begin
            check(got_b[i] == exp_b[i], "R2 stream byte", 32'(got_b[i]), 32'(exp_b[i]));
            check(got_e[i] == exp_e[i], "R3 end flag", 32'(got_e[i]), 32'(exp_e[i]));
        end

        // R5 R6: gather full and short words
        rxb(8'h11, 0); rxb(8'h22, 0); rxb(8'h33, 0); rxb(8'h44, 0);
        rxb(8'hA1, 0); rxb(8'hA2, 1);
        rxb(8'hB1, 1);
        rxb(8'hC1, 0); rxb(8'hC2, 0); rxb(8'hC3, 1);
        // R10: queue full, this word is lost
        rxb(8'hD1, 0); rxb(8'hD2, 0); rxb(8'hD3, 0); rxb(8'hD4, 0);
        rd(8'h24);                    // R7: other address leaves rdata alone
        check(bus_rdata == 0, "R7 hold", bus_rdata, 0);
        for (int i = 0; i < 4; i++) begin
            rd(8'h20);
            check(bus_rdata == exp_w[i], i == 0 ? "R5 full word" : "R6 short word",
                  bus_rdata, exp_w[i]);
        end
        rd(8'h20);
        check(rx_underflow == 1 && bus_rdata == 0, "R10 R8 empty after drop",
              {rx_underflow, bus_rdata[30:0]}, 32'h80000000);
        cyc();
        check(bus_rdata == 0 && rx_underflow == 0, "R8 pulse ends",
              bus_rdata, 0);

        // Push and read in the same cycle
        rxb(8'hE1, 1);
        rx_valid = 1; rx_byte = 8'hF1; rx_last = 1; bus_rd = 1; bus_addr = 8'h20;
        cyc();
        rx_valid = 0; rx_last = 0; bus_rd = 0;
        check(bus_rdata == 32'hE1000000, "R7 read during push", bus_rdata, 32'hE1000000);
        rd(8'h20);
        check(bus_rdata == 32'hF1000000, "R6 one byte word", bus_rdata, 32'hF1000000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule